// File: doc/BRIEF.md
# Write Ordering Commit Gate

This block decides, in every cycle, whether a pending internal write may commit to a cache line. It sits between the write merge buffer, the external bus write path and the cache write port. It looks at the target line's coherence state, the target's memory type, whether the merge buffer still holds writes that have not drained, and an active-low pin from the system that reports an empty external write buffer. From these inputs it drives a one-cycle commit grant or a stall.

Two bits of a small extended feature register set how strictly writes are ordered. In the strongest level, every internal write waits behind pending merge-buffer writes. In the relaxed level, only cacheable writes wait. In the open level, nothing is ordered and the pin is ignored. In the first two levels the system can also hold commits to Modified or Exclusive lines by keeping the pin negated until its own external write has completed. A later write that hits the cache then cannot overtake that external write.

The requester keeps a stalled request (line state, memory type and payload) unchanged until it sees the grant. It retires exactly one write for each cycle in which the grant is high.

Top module: `wo_commit_gate`

## Requirements
- R1: After reset, both ordering-control bits are 0, which selects the strongest level. The synchronised empty pin starts in its negated (high) state, so a Modified/Exclusive write stalls until the pin has been seen low.
- R2: When `feat_we` is 1 at a rising edge, the feature register loads `feat_wdata`. Bit 3 is the global disable and bit 2 is the speculative disable. All other bits, and any data presented while `feat_we` is 0, have no effect on commit decisions.
- R3: With bit 3 set to 1, `commit_grant` equals `req_valid`, whatever the values of bit 2, `mb_pending`, the pin, the memory type and the line state.
- R4: With bits 3 and 2 both 0, a valid write never gets a grant while `mb_pending` is 1, for every memory type.
- R5: With bit 3 at 0 and bit 2 at 1, `mb_pending` holds writes whose memory type is cacheable (WB=2, or the unused code 3). Writes with UC=0 or WC=1 are not held by it.
- R6: In either level with bit 3 at 0, while the synchronised pin is high (negated), a write to a line in state M=0 or E=1 is not granted.
- R7: Writes to lines in state S=2 or I=3 are never held by the pin. They follow only the merge-buffer rule of the active level.
- R8: A change on `ext_empty_n` affects the commit decision only after it has been captured by two rising clock edges.
- R9: `commit_stall` is 1 exactly when `req_valid` is 1 and `commit_grant` is 0. Both outputs are 0 when no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_we | input | 1 | Feature register write strobe |
| feat_wdata | input | FEAT_W | Feature register write data (bit 3 global disable, bit 2 speculative disable) |
| req_valid | input | 1 | Cache write request pending |
| req_line_state | input | 2 | Target line state: 0=M, 1=E, 2=S, 3=I |
| req_mem_type | input | 2 | Target memory type: 0=UC, 1=WC, 2=WB, 3 handled as cacheable |
| mb_pending | input | 1 | Merge buffer holds undrained older writes |
| ext_empty_n | input | 1 | Asynchronous active-low external write buffer empty pin |
| commit_grant | output | 1 | The write commits to the cache in this cycle |
| commit_stall | output | 1 | A valid write is being held in this cycle |

## Verification
The bench builds the block with its default values: an 8-bit feature register with the control bits at positions 3 and 2, and a two-stage pin synchroniser. This configuration is small enough to sweep exhaustively. Every ordering level is programmed with all unrelated feature bits set, and under each level and each settled pin level the bench tries every combination of request valid, merge-buffer flag, line state and memory type. It then checks the reset state, the two-edge pin latency in both directions, and that a feature write without the strobe is ignored.

// File: rtl/wo_pkg.sv
package wo_pkg;

   typedef enum logic [1:0] {
      LS_MOD = 2'd0,
      LS_EXC = 2'd1,
      LS_SHR = 2'd2,
      LS_INV = 2'd3
   } line_state_e;

   typedef enum logic [1:0] {
      MT_UC  = 2'd0,
      MT_WC  = 2'd1,
      MT_WB  = 2'd2,
      MT_RSV = 2'd3
   } mem_type_e;

   typedef enum logic [1:0] {
      ORD_STRONG = 2'd0,
      ORD_SPEC   = 2'd1,
      ORD_OPEN   = 2'd2
   } ord_level_e;

   function automatic logic is_pin_gated_state(input logic [1:0] st);
      return (st == LS_MOD) || (st == LS_EXC);
   endfunction

   function automatic logic is_bypass_type(input logic [1:0] mt);
      return (mt == MT_UC) || (mt == MT_WC);
   endfunction

endpackage

// File: rtl/wo_pin_sync.sv
module wo_pin_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("wo_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= RESET_VAL;
      else        stage_q[0] <= pin_i;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[i] <= RESET_VAL;
         else        stage_q[i] <= stage_q[i-1];
      end

      // R8: every stage adds exactly one edge of delay
      assert_stage_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> stage_q[i] == $past(stage_q[i-1]));
   end

   assign sync_o = stage_q[STAGES-1];

   assert_first_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> stage_q[0] == $past(pin_i));

endmodule

// File: rtl/wo_feat_reg.sv
module wo_feat_reg
   import wo_pkg::*;
#(
   parameter int FEAT_W     = 8,
   parameter int GLOBAL_BIT = 3,
   parameter int SPEC_BIT   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [FEAT_W-1:0] wdata_i,
   output ord_level_e        level_o
);

   if (GLOBAL_BIT >= FEAT_W || SPEC_BIT >= FEAT_W) begin : g_bad_pos
      $error("wo_feat_reg: control bit outside register");
   end
   if (GLOBAL_BIT == SPEC_BIT) begin : g_bad_overlap
      $error("wo_feat_reg: control bits must differ");
   end

   logic glob_dis_q;
   logic spec_dis_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_dis_q <= 1'b0;
         spec_dis_q <= 1'b0;
      end else if (we_i) begin
         glob_dis_q <= wdata_i[GLOBAL_BIT];
         spec_dis_q <= wdata_i[SPEC_BIT];
      end
   end

   always_comb begin
      if (glob_dis_q)      level_o = ORD_OPEN;
      else if (spec_dis_q) level_o = ORD_SPEC;
      else                 level_o = ORD_STRONG;
   end

   assert_hold_without_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(level_o));

   assert_reset_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> level_o == ORD_STRONG);

endmodule

// File: rtl/wo_policy.sv
module wo_policy
   import wo_pkg::*;
(
   input  ord_level_e level_i,
   input  logic       valid_i,
   input  logic [1:0] line_state_i,
   input  logic [1:0] mem_type_i,
   input  logic       mb_pending_i,
   input  logic       pin_negated_i,
   output logic       grant_o,
   output logic       stall_o
);

   logic order_needed;
   logic mb_hold;
   logic pin_hold;
   logic allow;

   always_comb begin
      unique case (level_i)
         ORD_OPEN:   order_needed = 1'b0;
         ORD_SPEC:   order_needed = !is_bypass_type(mem_type_i);
         default:    order_needed = 1'b1;
      endcase
      mb_hold  = order_needed && mb_pending_i;
      pin_hold = (level_i != ORD_OPEN) && pin_negated_i
                 && is_pin_gated_state(line_state_i);
      allow    = !mb_hold && !pin_hold;
      grant_o  = valid_i && allow;
      stall_o  = valid_i && !allow;
   end

endmodule

// File: rtl/wo_commit_gate.sv
module wo_commit_gate
   import wo_pkg::*;
#(
   parameter int FEAT_W      = 8,
   parameter int GLOBAL_BIT  = 3,
   parameter int SPEC_BIT    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              feat_we,
   input  logic [FEAT_W-1:0] feat_wdata,
   input  logic              req_valid,
   input  logic [1:0]        req_line_state,
   input  logic [1:0]        req_mem_type,
   input  logic              mb_pending,
   input  logic              ext_empty_n,
   output logic              commit_grant,
   output logic              commit_stall
);

   ord_level_e level;
   logic       pin_sync;

   wo_feat_reg #(
      .FEAT_W    (FEAT_W),
      .GLOBAL_BIT(GLOBAL_BIT),
      .SPEC_BIT  (SPEC_BIT)
   ) u_feat (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (feat_we),
      .wdata_i(feat_wdata),
      .level_o(level)
   );

   wo_pin_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (ext_empty_n),
      .sync_o(pin_sync)
   );

   wo_policy u_policy (
      .level_i      (level),
      .valid_i      (req_valid),
      .line_state_i (req_line_state),
      .mem_type_i   (req_mem_type),
      .mb_pending_i (mb_pending),
      .pin_negated_i(pin_sync),
      .grant_o      (commit_grant),
      .stall_o      (commit_stall)
   );

   assert_open_grants_R3: assert property (@(posedge clk) disable iff (!rst_n)
      level == ORD_OPEN |-> commit_grant == req_valid);

   assert_strong_mb_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (level == ORD_STRONG && mb_pending) |-> !commit_grant);

   assert_spec_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (level == ORD_SPEC && req_valid && is_bypass_type(req_mem_type)
       && !is_pin_gated_state(req_line_state)) |-> commit_grant);

   assert_pin_holds_me_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (level != ORD_OPEN && pin_sync && is_pin_gated_state(req_line_state))
      |-> !commit_grant);

   assert_si_free_of_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (level == ORD_STRONG && req_valid && !mb_pending
       && !is_pin_gated_state(req_line_state)) |-> commit_grant);

   assert_grant_stall_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_grant && commit_stall));

   assert_outputs_cover_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_grant || commit_stall) == req_valid);

endmodule

// File: tb/tb_wo_commit_gate.sv
`timescale 1ns/1ps
module tb_wo_commit_gate;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       feat_we = 1'b0;
   logic [7:0] feat_wdata = 8'h00;
   logic       req_valid = 1'b0;
   logic [1:0] req_line_state = 2'd0;
   logic [1:0] req_mem_type = 2'd2;
   logic       mb_pending = 1'b0;
   logic       ext_empty_n = 1'b0;
   logic       commit_grant;
   logic       commit_stall;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   wo_commit_gate dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .feat_we       (feat_we),
      .feat_wdata    (feat_wdata),
      .req_valid     (req_valid),
      .req_line_state(req_line_state),
      .req_mem_type  (req_mem_type),
      .mb_pending    (mb_pending),
      .ext_empty_n   (ext_empty_n),
      .commit_grant  (commit_grant),
      .commit_stall  (commit_stall)
   );

   function automatic bit model_grant(bit v, bit g, bit s, bit mb, bit pin,
                                      bit [1:0] st, bit [1:0] mt);
      bit ordered;
      if (!v) return 0;
      if (g) return 1;
      ordered = s ? (mt >= 2) : 1'b1;
      if (ordered && mb) return 0;
      if (pin && st < 2) return 0;
      return 1;
   endfunction

   task automatic check(bit exp_g, bit exp_v, string tag);
      bit exp_s;
      exp_s = exp_v && !exp_g;
      checks++;
      if (commit_grant !== exp_g || commit_stall !== exp_s) begin
         errors++;
         $display("FAIL %s: grant=%b stall=%b expected grant=%b stall=%b",
                  tag, commit_grant, commit_stall, exp_g, exp_s);
      end
   endtask

   task automatic drive(bit v, bit [1:0] st, bit [1:0] mt, bit mb);
      req_valid = v; req_line_state = st; req_mem_type = mt; mb_pending = mb;
   endtask

   task automatic write_feat(bit we, bit [7:0] d);
      @(posedge clk); #1;
      feat_we = we; feat_wdata = d;
      @(posedge clk); #1;
      feat_we = 1'b0; feat_wdata = 8'h00;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      ext_empty_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: synchroniser still shows negated pin: M write stalls
      drive(1, 2'd0, 2'd2, 0);
      @(negedge clk); check(0, 1, "R1 reset pin state");
      // R1: strongest level: UC write to S line held by merge buffer
      @(posedge clk); #1 drive(1, 2'd2, 2'd0, 1);
      @(negedge clk); check(0, 1, "R1 reset level strong");

      // exhaustive sweep; unrelated feature bits all set (R2)
      for (int m = 0; m < 4; m++) begin
         bit g, s;
         g = m[1]; s = m[0];
         write_feat(1, 8'hF3 | 8'(m << 2));
         for (int p = 0; p < 2; p++) begin
            @(posedge clk); #1 ext_empty_n = p[0]; drive(0, 0, 0, 0);
            repeat (3) @(posedge clk);
            for (int c = 0; c < 64; c++) begin
               bit v, mb; bit [1:0] st, mt;
               bit eg;
               string tag;
               v = c[0]; mb = c[1]; st = c[3:2]; mt = c[5:4];
               @(posedge clk); #1 drive(v, st, mt, mb);
               eg = model_grant(v, g, s, mb, p[0], st, mt);
               if (!v) tag = "R9 idle";
               else if (g) tag = "R3 open level";
               else if (mb && (!s || mt >= 2)) tag = s ? "R5 spec mb hold" : "R4 strong mb hold";
               else if (p[0] && st < 2) tag = "R6 pin holds M/E";
               else if (p[0]) tag = "R7 S/I ignore pin";
               else tag = s ? "R5 spec pass" : "R2 level decode";
               @(negedge clk); check(eg, v, tag);
            end
         end
      end

      // R2: data without strobe is ignored
      write_feat(1, 8'h00);
      write_feat(0, 8'hFF);
      @(posedge clk); #1 drive(1, 2'd3, 2'd1, 1);
      @(negedge clk); check(0, 1, "R2 no strobe keeps strong");
      write_feat(0, 8'h04);
      @(posedge clk); #1 drive(1, 2'd3, 2'd1, 1);
      @(negedge clk); check(0, 1, "R2 no strobe keeps strong (spec data)");

      // R8: pin falling edge takes two edges
      @(posedge clk); #1 ext_empty_n = 1'b1; drive(0, 0, 0, 0);
      repeat (3) @(posedge clk);
      #1 ext_empty_n = 1'b0; drive(1, 2'd1, 2'd2, 0);
      @(negedge clk); check(0, 1, "R8 fall 0 edges");
      @(negedge clk); check(0, 1, "R8 fall 1 edge");
      @(negedge clk); check(1, 1, "R8 fall 2 edges");
      @(posedge clk); #1 ext_empty_n = 1'b1;
      @(negedge clk); check(1, 1, "R8 rise 0 edges");
      @(negedge clk); check(1, 1, "R8 rise 1 edge");
      @(negedge clk); check(0, 1, "R8 rise 2 edges");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule